// File: doc/BRIEF.md
# I/O Window Chip-Select Decoder

This block sits between an I/O access path and the external device bus. It compares each I/O read or write against two windows that software programs. It then produces three things: the device address, an active-low strobe that marks the access as I/O space, and a 3-bit device select code with two active-low plug-in slot selects decoded from it.

Each window has a start address (low and high byte), a size register and a control register. The size register holds the window size in bytes minus one, and the size must be a power of two from 1 to 256. The control register holds the select code, an enable bit and an overlap bit. An enabled window in overlap mode claims the whole 64K I/O space.

The address is always forwarded to the device bus during an access, whether or not a window matches. Software programs the windows through a small synchronous write port with a combinational read-back.

Top module: `io_window_decode`

## Requirements
- R1: While io_rd or io_wr is high, dev_addr[15:0] equals io_addr and dev_addr[25:16] is zero. This holds whether or not any window matches.
- R2: During an access that matches an enabled window, space_sel_n is 0. When no enabled window matches, space_sel_n is 1, sel_code is 000 and both slot_cs_n bits are 1.
- R3: A window with size register S matches when the access address lies in the S+1 bytes that start at its start address. S+1 is a power of two, and the start address is aligned to S+1. Address bits [15:8] are always compared.
- R4: A window that is enabled and has its overlap bit set matches every address in 0x0000 to 0xFFFF.
- R5: After reset, every register reads 0. Both windows are therefore disabled, and the select codes are 000, which is not a valid device code.
- R6: sel_code carries the matching window's code unchanged. Code 101 drives slot_cs_n = 2'b10 (slot 0). Code 110 drives slot_cs_n = 2'b01 (slot 1). Any other code leaves slot_cs_n = 2'b11.
- R7: When both windows match, window 0's code is used.
- R8: Register offsets on reg_addr are:
  - 0, 1, 2, 3: window 0 start-low, start-high, size, control.
  - 4, 5, 6, 7: the same four registers for window 1.

  Control bits [2:0] hold the code, bit 3 is enable and bit 4 is overlap. Control bits [7:5] read as zero.
- R9: A window whose enable bit is 0 never matches, even with its overlap bit set.
- R10: With io_rd and io_wr both low, dev_addr is zero, space_sel_n is 1, sel_code is 000 and slot_cs_n is 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for register writes |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 16 | I/O address |
| dev_addr | output | 26 | Device address bus |
| space_sel_n | output | 1 | Active-low I/O space strobe, low on a window match |
| sel_code | output | 3 | Select code of the matching window |
| slot_cs_n | output | 2 | Active-low plug-in slot selects |

## Verification
The assertions assume that io_rd and io_wr are never both high. They also assume that software keeps each start address aligned to its size and keeps every size value one less than a power of two; the match is only meaningful under those conditions.

The bench programs only aligned windows with legal sizes. It gives each access exactly one strobe, or none, and it changes registers only between full address sweeps. Each sweep covers all 65536 addresses, and the bench computes the expected match by integer division instead of bit masking.

// File: rtl/io_window_decode.sv
module io_window_decode #(
  parameter int NWIN = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        io_rd,
  input  logic        io_wr,
  input  logic [15:0] io_addr,
  output logic [25:0] dev_addr,
  output logic        space_sel_n,
  output logic [2:0]  sel_code,
  output logic [1:0]  slot_cs_n
);

  localparam logic [2:0] CODE_SLOT0 = 3'b101;
  localparam logic [2:0] CODE_SLOT1 = 3'b110;

  logic [7:0] start_lo [NWIN];
  logic [7:0] start_hi [NWIN];
  logic [7:0] size_m1  [NWIN];
  logic [2:0] code     [NWIN];
  logic       win_en   [NWIN];
  logic       win_ov   [NWIN];
  logic [NWIN-1:0] hit;

  wire access = io_rd | io_wr;
  wire win_sel = reg_addr[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWIN; i++) begin
        start_lo[i] <= '0;
        start_hi[i] <= '0;
        size_m1[i]  <= '0;
        code[i]     <= '0;
        win_en[i]   <= 1'b0;
        win_ov[i]   <= 1'b0;
      end
    end else if (reg_we) begin
      case (reg_addr[1:0])
        2'd0: start_lo[win_sel] <= reg_wdata;
        2'd1: start_hi[win_sel] <= reg_wdata;
        2'd2: size_m1[win_sel]  <= reg_wdata;
        default: begin
          code[win_sel]   <= reg_wdata[2:0];
          win_en[win_sel] <= reg_wdata[3];
          win_ov[win_sel] <= reg_wdata[4];
        end
      endcase
    end
  end

  always_comb begin
    case (reg_addr[1:0])
      2'd0:    reg_rdata = start_lo[win_sel];
      2'd1:    reg_rdata = start_hi[win_sel];
      2'd2:    reg_rdata = size_m1[win_sel];
      default: reg_rdata = {3'b000, win_ov[win_sel], win_en[win_sel], code[win_sel]};
    endcase
  end

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    wire [15:0] diff = io_addr ^ {start_hi[w], start_lo[w]};
    assign hit[w] = win_en[w] & (win_ov[w] | ((diff & ~{8'h00, size_m1[w]}) == 16'h0000));
  end

  wire any_hit = access & (|hit);

  assign dev_addr    = access ? {10'b0, io_addr} : 26'b0;
  assign space_sel_n = ~any_hit;

  always_comb begin
    sel_code = 3'b000;
    if (access) begin
      for (int w = NWIN - 1; w >= 0; w--)
        if (hit[w]) sel_code = code[w];
    end
  end

  assign slot_cs_n[0] = ~(any_hit && sel_code == CODE_SLOT0);
  assign slot_cs_n[1] = ~(any_hit && sel_code == CODE_SLOT1);

  p_addr_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    access |-> (dev_addr[25:16] == 10'b0 && dev_addr[15:0] == io_addr));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !access |-> (space_sel_n && slot_cs_n == 2'b11 && dev_addr == 26'b0));

  p_slot_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~slot_cs_n));

  p_slot_needs_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_cs_n != 2'b11) |-> !space_sel_n);

  p_disabled_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_en[0] && !win_en[1]) |-> space_sel_n);

  p_win0_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (access && win_en[0] && win_ov[0]) |-> sel_code == code[0]);

endmodule

// File: tb/io_window_decode_tb.sv
module io_window_decode_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        io_rd = 1'b0;
  logic        io_wr = 1'b0;
  logic [15:0] io_addr = '0;
  logic [25:0] dev_addr;
  logic        space_sel_n;
  logic [2:0]  sel_code;
  logic [1:0]  slot_cs_n;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  int m_start [2];
  int m_size  [2];
  int m_code  [2];
  int m_en    [2];
  int m_ov    [2];

  io_window_decode u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .io_rd(io_rd),
    .io_wr(io_wr), .io_addr(io_addr), .dev_addr(dev_addr),
    .space_sel_n(space_sel_n), .sel_code(sel_code), .slot_cs_n(slot_cs_n));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 180000 && !done) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s addr=%h: actual %0h expected %0h", tag, io_addr, act, exp);
    end
  endtask

  task automatic wr_reg(input int off, input int val);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = off[2:0]; reg_wdata = val[7:0];
    @(negedge clk);
    reg_we = 1'b0;
    if (off[1:0] == 2'd0) m_start[off/4] = (m_start[off/4] & 'hFF00) | (val & 'hFF);
    if (off[1:0] == 2'd1) m_start[off/4] = (m_start[off/4] & 'h00FF) | ((val & 'hFF) << 8);
    if (off[1:0] == 2'd2) m_size[off/4] = val & 'hFF;
    if (off[1:0] == 2'd3) begin
      m_code[off/4] = val & 7;
      m_en[off/4]   = (val >> 3) & 1;
      m_ov[off/4]   = (val >> 4) & 1;
    end
  endtask

  task automatic set_win(input int w, input int start, input int size, input int ctl);
    wr_reg(w*4 + 0, start & 'hFF);
    wr_reg(w*4 + 1, (start >> 8) & 'hFF);
    wr_reg(w*4 + 2, size);
    wr_reg(w*4 + 3, ctl);
  endtask

  function automatic int model_hit(input int w, input int a);
    int blk = m_size[w] + 1;
    if (m_en[w] == 0) return 0;
    if (m_ov[w] != 0) return 1;
    return (a / blk) == (m_start[w] / blk) ? 1 : 0;
  endfunction

  task automatic sweep(input int phase);
    for (int a = 0; a < 65536; a++) begin
      int s = (a + phase) % 3;
      int acc, h0, h1, ecode, ehit, eslot;
      io_addr = a[15:0];
      io_rd = (s == 0);
      io_wr = (s == 1);
      #1;
      acc = (s != 2) ? 1 : 0;
      h0 = model_hit(0, a);
      h1 = model_hit(1, a);
      ehit = acc & (h0 | h1);
      ecode = !acc ? 0 : h0 ? m_code[0] : h1 ? m_code[1] : 0;
      eslot = 3;
      if (ehit && ecode == 5) eslot = 2;
      if (ehit && ecode == 6) eslot = 1;
      chk(acc ? "R1 dev_addr" : "R10 dev_addr idle", int'(dev_addr), acc ? a : 0);
      chk("R2/R3/R4/R9 space_sel_n", int'(space_sel_n), ehit ? 0 : 1);
      chk("R6/R7 sel_code", int'(sel_code), ecode);
      chk("R6 slot_cs_n", int'(slot_cs_n), eslot);
    end
    io_rd = 1'b0; io_wr = 1'b0;
  endtask

  task automatic check_regs(input string tag);
    for (int r = 0; r < 8; r++) begin
      int exp;
      reg_addr = r[2:0];
      #1;
      case (r % 4)
        0: exp = m_start[r/4] & 'hFF;
        1: exp = (m_start[r/4] >> 8) & 'hFF;
        2: exp = m_size[r/4];
        default: exp = m_code[r/4] | (m_en[r/4] << 3) | (m_ov[r/4] << 4);
      endcase
      chk(tag, int'(reg_rdata), exp);
    end
  endtask

  initial begin
    for (int w = 0; w < 2; w++) begin
      m_start[w] = 0; m_size[w] = 0; m_code[w] = 0; m_en[w] = 0; m_ov[w] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: reset state reads zero and nothing matches
    check_regs("R5 reset regs");
    sweep(0);

    // R8: offsets and control layout, upper control bits read zero
    wr_reg(0, 'h11); wr_reg(1, 'h22); wr_reg(2, 'h33); wr_reg(3, 'hE7);
    wr_reg(4, 'h44); wr_reg(5, 'h55); wr_reg(6, 'h66); wr_reg(7, 'hF2);
    check_regs("R8 regmap");

    // R3, R6: small windows, slot 0 and slot 1
    set_win(0, 'h1200, 'h03, 'h0D);
    set_win(1, 'h1280, 'h7F, 'h0E);
    sweep(1);

    // R4, R7: window 0 has priority over an overlap window
    set_win(0, 'h4000, 'hFF, 'h0E);
    set_win(1, 'h0000, 'h00, 'h1D);
    sweep(2);

    // R9, R6: disabled overlap window, one-byte window with an invalid code
    set_win(0, 'h0000, 'h00, 'h15);
    set_win(1, 'hABCD, 'h00, 'h0B);
    sweep(0);

    // R7: nested windows in the same region
    set_win(0, 'h3000, 'h0F, 'h0D);
    set_win(1, 'h3000, 'h3F, 'h0E);
    sweep(1);

    // R5: a second reset clears everything
    @(negedge clk);
    rst_n = 1'b0;
    for (int w = 0; w < 2; w++) begin
      m_start[w] = 0; m_size[w] = 0; m_code[w] = 0; m_en[w] = 0; m_ov[w] = 0;
    end
    @(negedge clk);
    rst_n = 1'b1;
    check_regs("R5 re-reset regs");
    sweep(2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule